// File: doc/BRIEF.md
# Keyed Watchdog Reset Controller

A watchdog that issues a fixed-length reset pulse when software stops servicing it. A 64-bit count, split into two 32-bit halves, advances once per clock while the watchdog is running. A reset pulse is raised when that count reaches a programmed 64-bit limit. Software controls the watchdog by writing 16-bit key values, together with a sticky enable bit, into a control word. One key opens a sequence and a second key completes it. The first completed sequence starts the watchdog. Each later sequence restarts the count from zero. If a key is written out of order while the watchdog runs, the reset fires at once.

Key writes take effect only when the mode word selects the watchdog timer mode and both counter halves are released from reset. While the watchdog runs, the mode, limit and count words are frozen against writes. This stops software from weakening a watchdog that is already armed. All register traffic is plain control: there is a single-cycle write strobe, and the read port is combinational. Neither port has a handshake, and writes are never stalled.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the control word reads state code 0 (idle) in bits [1:0] and enable bit 14 clear, the mode, count and limit words read 0, and `wdog_rst_o` is low.
- R2: A control-word write (word address 0) has no effect unless the mode word (address 1) holds 2 in bits [1:0] and both half-release bits 8 and 9 are set.
- R3: From idle, key 0xA5C6 in control bits [31:16] moves the state to pre-active (code 1), but only if enable bit 14 is written as 1 or is already set. With enable clear the state stays idle.
- R4: From pre-active, key 0xDA7E moves the state to active (code 2) and clears the 64-bit count. Any other key leaves the state at pre-active.
- R5: Once set, the enable bit stays set until block reset. Writes that carry bit 14 as 0 neither clear it nor stop the key sequence.
- R6: While active, the count (low word at address 2, high word at address 3) rises by one each clock. When it equals the limit (low word at address 4, high word at address 5), the reset output rises on the following clock. With limit P, this is P+1 clocks after the edge that starts or restarts the count.
- R7: While active, key 0xA5C6 moves the state to half-serviced (code 3). A following 0xDA7E clears the count and returns the state to active (code 2).
- R8: While active or half-serviced, a key the sequence does not expect (for example, control word 0x00004000) raises the reset output on the clock after the write.
- R9: The reset output stays high for exactly 8 clocks. Each reset event returns the state to idle and clears the count.
- R10: While active or half-serviced, writes to the mode, count and limit words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| wr_en_i | input | 1 | Register write strobe, one write per high cycle |
| wr_addr_i | input | 3 | Word address of the write |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Word address of the combinational read |
| rd_data_o | output | 32 | Read data |
| wdog_rst_o | output | 1 | Reset request pulse, 8 clocks long |

## Verification
The hardest case to reach from the ports is a timeout that arrives after a service sequence. To reach it, the stimulus must enter watchdog mode, program the limit and complete the arming keys. It must then let the count run part way and split the service across two separate writes, checking state code 3 between them. After the second key, it counts the clocks to the reset edge from the restart, not from the original arming. Reading the count immediately after the second key confirms that it restarted. A second scenario stops in the half-serviced state and writes an unexpected key there, which must fire just as an unexpected key does in the fully active state.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int ADDR_W = 3;
  localparam int KEY_W  = 16;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNTL = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNTH = 3'd3;
  localparam logic [ADDR_W-1:0] A_PRDL = 3'd4;
  localparam logic [ADDR_W-1:0] A_PRDH = 3'd5;

  localparam logic [KEY_W-1:0] KEY_OPEN  = 16'hA5C6;
  localparam logic [KEY_W-1:0] KEY_CLOSE = 16'hDA7E;

  localparam int EN_BIT     = 14;
  localparam int RUN_LO_BIT = 8;
  localparam int RUN_HI_BIT = 9;
  localparam logic [1:0] MODE_WDOG = 2'd2;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_PRE  = 2'd1,
    WS_ACT  = 2'd2,
    WS_HALF = 2'd3
  } wd_state_e;
endpackage

// File: rtl/wdk_cfg.sv
module wdk_cfg
  import wdk_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [HALF_W-1:0]   wr_data_i,
  input  logic                lock_i,
  output logic [1:0]          mode_o,
  output logic                run_lo_o,
  output logic                run_hi_o,
  output logic                mode_ok_o,
  output logic [2*HALF_W-1:0] prd_o,
  output logic [1:0]          cnt_wr_o
);
  logic mode_we;
  logic [1:0] prd_we;

  assign mode_we = wr_en_i && !lock_i && (wr_addr_i == A_MODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o   <= '0;
      run_lo_o <= 1'b0;
      run_hi_o <= 1'b0;
    end else if (mode_we) begin
      mode_o   <= wr_data_i[1:0];
      run_lo_o <= wr_data_i[RUN_LO_BIT];
      run_hi_o <= wr_data_i[RUN_HI_BIT];
    end
  end

  assign mode_ok_o = (mode_o == MODE_WDOG) && run_lo_o && run_hi_o;

  for (genvar g = 0; g < 2; g++) begin : g_half
    localparam logic [ADDR_W-1:0] PRD_ADDR = (g == 0) ? A_PRDL : A_PRDH;
    localparam logic [ADDR_W-1:0] CNT_ADDR = (g == 0) ? A_CNTL : A_CNTH;
    assign prd_we[g]   = wr_en_i && !lock_i && (wr_addr_i == PRD_ADDR);
    assign cnt_wr_o[g] = wr_en_i && !lock_i && (wr_addr_i == CNT_ADDR);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prd_o[g*HALF_W +: HALF_W] <= '0;
      else if (prd_we[g]) prd_o[g*HALF_W +: HALF_W] <= wr_data_i;
    end
  end

  assert_cfg_lock_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && wr_en_i) |=> ($stable(prd_o) && $stable(mode_o)));
endmodule

// File: rtl/wdk_keyfsm.sv
module wdk_keyfsm
  import wdk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             en_bit_i,
  input  logic             timeout_i,
  output wd_state_e        state_o,
  output logic             en_o,
  output logic             active_o,
  output logic             fire_o,
  output logic             restart_o
);
  wd_state_e nxt;
  logic en_eff, bad_key;

  assign en_eff = en_o || en_bit_i;

  always_comb begin
    nxt       = state_o;
    restart_o = 1'b0;
    bad_key   = 1'b0;
    if (ctrl_wr_i) begin
      unique case (state_o)
        WS_IDLE: if (en_eff && key_i == KEY_OPEN) nxt = WS_PRE;
        WS_PRE: begin
          if (en_eff && key_i == KEY_CLOSE) begin
            nxt       = WS_ACT;
            restart_o = 1'b1;
          end
        end
        WS_ACT: begin
          if (key_i == KEY_OPEN) nxt = WS_HALF;
          else bad_key = 1'b1;
        end
        WS_HALF: begin
          if (key_i == KEY_CLOSE) begin
            nxt       = WS_ACT;
            restart_o = 1'b1;
          end else if (key_i != KEY_OPEN) begin
            bad_key = 1'b1;
          end
        end
        default: nxt = WS_IDLE;
      endcase
    end
    fire_o = timeout_i || bad_key;
    if (fire_o) nxt = WS_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= WS_IDLE;
      en_o    <= 1'b0;
    end else begin
      state_o <= nxt;
      if (ctrl_wr_i && en_bit_i) en_o <= 1'b1;
    end
  end

  assign active_o = (state_o == WS_ACT) || (state_o == WS_HALF);

  assert_sticky_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |=> en_o);
  assert_need_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == WS_IDLE && !en_o && !en_bit_i) |=> (state_o == WS_IDLE));
  assert_bad_key_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && state_o == WS_ACT && key_i != KEY_OPEN) |=> (state_o == WS_IDLE));
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              clear_i,
  input  logic [1:0]        wr_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  prd_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              timeout_o
);
  logic [CNT_W-1:0] nxt;

  always_comb begin
    nxt = cnt_o;
    if (clear_i) begin
      nxt = '0;
    end else if (active_i) begin
      nxt = cnt_o + 1'b1;
    end else begin
      for (int h = 0; h < 2; h++)
        if (wr_i[h]) nxt[h*HALF_W +: HALF_W] = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else cnt_o <= nxt;
  end

  assign timeout_o = active_i && (cnt_o == prd_i);

  assert_count_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !clear_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_o == '0));
endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
  parameter int PULSE_CYC = 8,
  localparam int PC_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic rst_o
);
  logic [PC_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_o  <= 1'b0;
      left_q <= '0;
    end else if (fire_i) begin
      rst_o  <= 1'b1;
      left_q <= PC_W'(PULSE_CYC - 1);
    end else if (rst_o) begin
      if (left_q == '0) rst_o <= 1'b0;
      else left_q <= left_q - 1'b1;
    end
  end

  assert_pulse_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_o) |-> $past(fire_i));
  assert_pulse_fire_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> rst_o);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdk_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PULSE_CYC = 8,
  localparam int HALF_W   = DATA_W,
  localparam int CNT_W    = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              wdog_rst_o
);
  logic [1:0]       mode;
  logic             run_lo, run_hi, mode_ok;
  logic [CNT_W-1:0] prd, cnt;
  logic [1:0]       cnt_wr;
  logic             ctrl_wr, timeout, active, fire, restart, en;
  wd_state_e        state;

  assign ctrl_wr = wr_en_i && (wr_addr_i == A_CTRL) && mode_ok;

  wdk_cfg #(.HALF_W(HALF_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .lock_i(active), .mode_o(mode), .run_lo_o(run_lo),
    .run_hi_o(run_hi), .mode_ok_o(mode_ok), .prd_o(prd), .cnt_wr_o(cnt_wr)
  );

  wdk_keyfsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_wr_i(ctrl_wr),
    .key_i(wr_data_i[DATA_W-1 -: KEY_W]), .en_bit_i(wr_data_i[EN_BIT]),
    .timeout_i(timeout), .state_o(state), .en_o(en), .active_o(active),
    .fire_o(fire), .restart_o(restart)
  );

  wdk_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active), .clear_i(restart || fire),
    .wr_i(cnt_wr), .wdata_i(wr_data_i), .prd_i(prd), .cnt_o(cnt),
    .timeout_o(timeout)
  );

  wdk_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .rst_o(wdog_rst_o)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_CTRL: begin
        rd_data_o[EN_BIT] = en;
        rd_data_o[1:0]    = state;
      end
      A_MODE: begin
        rd_data_o[1:0]        = mode;
        rd_data_o[RUN_LO_BIT] = run_lo;
        rd_data_o[RUN_HI_BIT] = run_hi;
      end
      A_CNTL: rd_data_o = cnt[HALF_W-1:0];
      A_CNTH: rd_data_o = cnt[CNT_W-1:HALF_W];
      A_PRDL: rd_data_o = prd[HALF_W-1:0];
      A_PRDH: rd_data_o = prd[CNT_W-1:HALF_W];
      default: rd_data_o = '0;
    endcase
  end

  assert_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_ok && state == WS_IDLE) |=> (state == WS_IDLE));
  assert_reset_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdog_rst_o) |-> (state == WS_IDLE && cnt == '0));
endmodule

// File: tb/test_keyed_wdog.sv
`timescale 1ns/100ps
module test_keyed_wdog;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        wdog_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk_i = ~clk_i;

  keyed_wdog i_keyed_wdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .wdog_rst_o(wdog_rst_o)
  );

  localparam logic [31:0] MODE_ON = 32'h0000_0302;
  localparam logic [31:0] W_OPEN  = 32'hA5C6_4000;
  localparam logic [31:0] W_CLOSE = 32'hDA7E_4000;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr_i = a;
    #0.2;
    d = rd_data_o;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; wr_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic arm(input logic [31:0] p);
    wr(3'd1, MODE_ON);
    wr(3'd4, p);
    wr(3'd5, 32'h0);
    wr(3'd0, W_OPEN);
    wr(3'd0, W_CLOSE);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset();
    rd(3'd0, d); chk("R1 ctrl", d, 32'h0);
    rd(3'd1, d); chk("R1 mode", d, 32'h0);
    rd(3'd2, d); chk("R1 cnt", d, 32'h0);
    rd(3'd4, d); chk("R1 prd", d, 32'h0);
    chk("R1 rst out", wdog_rst_o, 1'b0);
  endtask

  task automatic t_mode_gate();
    logic [31:0] d;
    do_reset();
    wr(3'd0, W_OPEN);
    rd(3'd0, d); chk("R2 mode off", d, 32'h0);
    wr(3'd1, 32'h0000_0102);
    wr(3'd0, W_OPEN);
    rd(3'd0, d); chk("R2 high half held", d, 32'h0);
    wr(3'd1, 32'h0000_0301);
    wr(3'd0, W_OPEN);
    rd(3'd0, d); chk("R2 wrong mode", d, 32'h0);
  endtask

  task automatic t_enable_and_sticky();
    logic [31:0] d;
    do_reset();
    wr(3'd1, MODE_ON);
    wr(3'd0, 32'hA5C6_0000);
    rd(3'd0, d); chk("R3 no enable stays idle", d, 32'h0);
    wr(3'd0, W_OPEN);
    rd(3'd0, d); chk("R3 pre-active", d, 32'h0000_4001);
    wr(3'd0, 32'h0000_0000);
    rd(3'd0, d); chk("R5 R4 clear ignored, stays pre", d, 32'h0000_4001);
    wr(3'd0, 32'hDA7E_0000);
    rd(3'd0, d); chk("R5 R4 active with sticky enable", d, 32'h0000_4002);
    rd(3'd2, d); chk("R4 count cleared", d, 32'h0);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    do_reset();
    arm(32'd5);
    repeat (5) @(negedge clk_i);
    chk("R6 no reset at limit", wdog_rst_o, 1'b0);
    @(negedge clk_i);
    chk("R6 reset after limit", wdog_rst_o, 1'b1);
    rd(3'd0, d); chk("R9 back to idle", d[1:0], 2'd0);
    rd(3'd2, d); chk("R9 count cleared", d, 32'h0);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk_i);
      chk("R9 pulse held", wdog_rst_o, 1'b1);
    end
    @(negedge clk_i);
    chk("R9 pulse released after 8", wdog_rst_o, 1'b0);
  endtask

  task automatic t_service();
    logic [31:0] d;
    do_reset();
    arm(32'd20);
    repeat (10) @(negedge clk_i);
    wr(3'd0, W_OPEN);
    rd(3'd0, d); chk("R7 half-serviced", d[1:0], 2'd3);
    wr(3'd0, W_CLOSE);
    rd(3'd0, d); chk("R7 active again", d[1:0], 2'd2);
    rd(3'd2, d); chk("R7 count restarted", d, 32'h0);
    repeat (20) @(negedge clk_i);
    chk("R7 R6 timeout deferred", wdog_rst_o, 1'b0);
    @(negedge clk_i);
    chk("R6 timeout after restart", wdog_rst_o, 1'b1);
  endtask

  task automatic t_bad_key();
    do_reset();
    arm(32'd1000);
    chk("R8 quiet while active", wdog_rst_o, 1'b0);
    wr(3'd0, 32'h0000_4000);
    chk("R8 wrong key fires", wdog_rst_o, 1'b1);
    do_reset();
    arm(32'd1000);
    wr(3'd0, W_OPEN);
    wr(3'd0, 32'h1234_4000);
    chk("R8 wrong key in half state fires", wdog_rst_o, 1'b1);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    do_reset();
    arm(32'd1000);
    wr(3'd4, 32'd7);
    rd(3'd4, d); chk("R10 limit locked", d, 32'd1000);
    wr(3'd1, 32'h0);
    rd(3'd1, d); chk("R10 mode locked", d, MODE_ON);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, d); chk("R10 count high locked", d, 32'h0);
    rd(3'd2, d); chk("R10 R6 count still running", d, 32'd6);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_mode_gate();
    t_enable_and_sticky();
    t_timeout();
    t_service();
    t_bad_key();
    t_lock();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule